// File: doc/BRIEF.md
# Bank-Switchable Dual-Port Memory

This block is a clocked two-port word memory cut into a parameterised number of equal banks. The left port and the right port each have their own chip enables, write strobe, output enable, byte enables, bank number, in-bank word address and data buses. A per-bank ownership input hands every bank to exactly one of the two ports at any moment. A port can only touch the banks it currently holds. Because of this, both ports can run at full rate with no arbitration and no collision logic.

A system uses the ownership inputs to pass buffers between two agents. One side fills a bank while it owns it. The ownership bit is then flipped, and the other side reads the same contents. Writes aimed at a bank the port does not hold are dropped. Reads aimed at such a bank return zero. Read data is registered, so it leaves the block one clock after the request.

Top module: `bsdp_ram`

## Requirements
- R1: When both chip enables are high, `we` is high and the addressed bank is owned by the port, the clock edge stores the write data into that bank at the in-bank address.
- R2: When both chip enables are high, `we` is low, `oe` is high and the bank is owned, the word appears on that port's `rdata` after the next clock edge, one cycle of latency. In every other case `rdata` shows zero after the edge.
- R3: A port is active only when both `ce0` and `ce1` are high. With either one low, the port writes nothing and its `rdata` becomes zero.
- R4: Bit b of `bank_sel` gives bank b to the left port when 0 and to the right port when 1. The bank number on a port's `bank` input selects the bank, and the word address selects a word inside that bank.
- R5: A write to a bank owned by the other port is discarded, and the bank keeps its earlier contents.
- R6: A read from a bank owned by the other port returns zero.
- R7: `ube` enables data bits 15:8 and `lbe` enables bits 7:0. A write changes only the enabled bytes. A read returns zero in each disabled byte.
- R8: A read needs `oe` high with `we` low. With `oe` low, `rdata` becomes zero.
- R9: The two ports work independently. Accesses by both ports in the same cycle to banks each one owns both complete.
- R10: Changing `bank_sel` does not alter bank contents. The new owner reads what the previous owner wrote, and the switch takes effect from the very next edge.
- R11: While `rst_n` is low, both `rdata` outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read registers |
| bank_sel | input | BANKS | Per-bank owner: 0 left, 1 right |
| l_ce0 | input | 1 | Left chip enable 0, active high |
| l_ce1 | input | 1 | Left chip enable 1, active high |
| l_we | input | 1 | Left write strobe, 1 = write |
| l_oe | input | 1 | Left output enable |
| l_ube | input | 1 | Left upper byte enable (bits 15:8) |
| l_lbe | input | 1 | Left lower byte enable (bits 7:0) |
| l_bank | input | $clog2(BANKS) | Left bank number |
| l_addr | input | BANK_AW | Left word address inside the bank |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| r_ce0 | input | 1 | Right chip enable 0, active high |
| r_ce1 | input | 1 | Right chip enable 1, active high |
| r_we | input | 1 | Right write strobe, 1 = write |
| r_oe | input | 1 | Right output enable |
| r_ube | input | 1 | Right upper byte enable (bits 15:8) |
| r_lbe | input | 1 | Right lower byte enable (bits 7:0) |
| r_bank | input | $clog2(BANKS) | Right bank number |
| r_addr | input | BANK_AW | Right word address inside the bank |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |

## Verification
Each result has a fixed due time. A write takes effect at the edge that samples it. A read's data, or the zero that replaces it, shows on `rdata` just after the following edge. The bench drives inputs on the falling edge. At each rising edge it updates a behavioural bank model from the inputs that edge samples, and works out what each `rdata` must become. It compares both ports at the next falling edge, so every cycle is checked exactly one register stage after its stimulus. Writes that must be discarded are checked by later owned reads of the same word, through the ports.

// File: rtl/bsdp_pkg.sv
package bsdp_pkg;

   typedef enum logic {
      PORT_L = 1'b0,
      PORT_R = 1'b1
   } port_e;

   localparam int unsigned LANES = 2;

endpackage

// File: rtl/bsdp_port_dec.sv
module bsdp_port_dec #(
   parameter int unsigned BANKS = 4,
   parameter int unsigned BA_W  = 2
) (
   input  logic             ce0,
   input  logic             ce1,
   input  logic             we,
   input  logic             oe,
   input  logic [BA_W-1:0]  bank,
   output logic             wr_req,
   output logic             rd_req,
   output logic [BANKS-1:0] hit
);

   logic active;

   always_comb begin
      active = ce0 & ce1;
      wr_req = active & we;
      rd_req = active & ~we & oe;
   end

   for (genvar b = 0; b < BANKS; b++) begin : g_hit
      assign hit[b] = (bank == BA_W'(b));
   end

endmodule

// File: rtl/bsdp_bank.sv
module bsdp_bank
   import bsdp_pkg::*;
#(
   parameter int unsigned AW     = 8,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  port_e             owner,
   input  logic              l_wr,
   input  logic              l_rd,
   input  logic [AW-1:0]     l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   input  logic [LANES-1:0]  l_be,
   input  logic              r_wr,
   input  logic              r_rd,
   input  logic [AW-1:0]     r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   input  logic [LANES-1:0]  r_be,
   output logic [DATA_W-1:0] rd_q,
   output logic              to_l_q,
   output logic              to_r_q
);

   localparam int unsigned WORDS = 1 << AW;
   localparam int unsigned HALF  = DATA_W / LANES;

   logic [DATA_W-1:0] mem [WORDS];

   logic              s_wr;
   logic              s_rd;
   logic [AW-1:0]     s_addr;
   logic [DATA_W-1:0] s_wdata;
   logic [LANES-1:0]  s_be;
   logic [DATA_W-1:0] s_rmask;

   always_comb begin
      if (owner == PORT_L) begin
         s_wr    = l_wr;
         s_rd    = l_rd;
         s_addr  = l_addr;
         s_wdata = l_wdata;
         s_be    = l_be;
      end else begin
         s_wr    = r_wr;
         s_rd    = r_rd;
         s_addr  = r_addr;
         s_wdata = r_wdata;
         s_be    = r_be;
      end
   end

   always_comb begin
      s_rmask = '0;
      for (int ln = 0; ln < LANES; ln++) begin
         if (s_be[ln]) begin
            s_rmask[ln*HALF +: HALF] = mem[s_addr][ln*HALF +: HALF];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (s_wr) begin
         for (int ln = 0; ln < LANES; ln++) begin
            if (s_be[ln]) begin
               mem[s_addr][ln*HALF +: HALF] <= s_wdata[ln*HALF +: HALF];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q   <= '0;
         to_l_q <= 1'b0;
         to_r_q <= 1'b0;
      end else if (s_rd) begin
         rd_q   <= s_rmask;
         to_l_q <= (owner == PORT_L);
         to_r_q <= (owner == PORT_R);
      end else begin
         rd_q   <= '0;
         to_l_q <= 1'b0;
         to_r_q <= 1'b0;
      end
   end

   AST_FOREIGN_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (owner == PORT_R && l_wr && !(r_wr && r_addr == l_addr))
      |=> mem[$past(l_addr)] === $past(mem[l_addr])); // R5

   AST_SINGLE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      !(to_l_q && to_r_q)); // R9

endmodule

// File: rtl/bsdp_rd_merge.sv
module bsdp_rd_merge #(
   parameter int unsigned BANKS  = 4,
   parameter int unsigned DATA_W = 16
) (
   input  logic [BANKS-1:0][DATA_W-1:0] data,
   input  logic [BANKS-1:0]             route,
   output logic [DATA_W-1:0]            q
);

   always_comb begin
      q = '0;
      for (int b = 0; b < BANKS; b++) begin
         if (route[b]) begin
            q = q | data[b];
         end
      end
   end

endmodule

// File: rtl/bsdp_ram.sv
module bsdp_ram
   import bsdp_pkg::*;
#(
   parameter int unsigned BANKS   = 4,
   parameter int unsigned BANK_AW = 8,
   parameter int unsigned DATA_W  = 16,
   localparam int unsigned BA_W   = $clog2(BANKS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [BANKS-1:0]   bank_sel,
   input  logic               l_ce0,
   input  logic               l_ce1,
   input  logic               l_we,
   input  logic               l_oe,
   input  logic               l_ube,
   input  logic               l_lbe,
   input  logic [BA_W-1:0]    l_bank,
   input  logic [BANK_AW-1:0] l_addr,
   input  logic [DATA_W-1:0]  l_wdata,
   output logic [DATA_W-1:0]  l_rdata,
   input  logic               r_ce0,
   input  logic               r_ce1,
   input  logic               r_we,
   input  logic               r_oe,
   input  logic               r_ube,
   input  logic               r_lbe,
   input  logic [BA_W-1:0]    r_bank,
   input  logic [BANK_AW-1:0] r_addr,
   input  logic [DATA_W-1:0]  r_wdata,
   output logic [DATA_W-1:0]  r_rdata
);

   localparam int unsigned HALF = DATA_W / LANES;

   initial begin
      AST_PARAM_BANKS: assert (BANKS >= 2 && (1 << BA_W) == BANKS)
         else $error("BANKS must be a power of two, at least 2");
      AST_PARAM_WIDTH: assert (DATA_W >= 2 && DATA_W % LANES == 0)
         else $error("DATA_W must split into two equal byte lanes");
      AST_PARAM_DEPTH: assert (BANK_AW >= 1)
         else $error("BANK_AW must be at least 1");
   end

   logic             l_wr, l_rd, r_wr, r_rd;
   logic [BANKS-1:0] l_hit, r_hit;
   logic [BANKS-1:0] route_l, route_r;
   logic [BANKS-1:0][DATA_W-1:0] bank_q;

   bsdp_port_dec #(.BANKS(BANKS), .BA_W(BA_W)) u_dec_l (
      .ce0(l_ce0), .ce1(l_ce1), .we(l_we), .oe(l_oe), .bank(l_bank),
      .wr_req(l_wr), .rd_req(l_rd), .hit(l_hit)
   );

   bsdp_port_dec #(.BANKS(BANKS), .BA_W(BA_W)) u_dec_r (
      .ce0(r_ce0), .ce1(r_ce1), .we(r_we), .oe(r_oe), .bank(r_bank),
      .wr_req(r_wr), .rd_req(r_rd), .hit(r_hit)
   );

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      bsdp_bank #(.AW(BANK_AW), .DATA_W(DATA_W)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .owner   (port_e'(bank_sel[b])),
         .l_wr    (l_wr & l_hit[b]),
         .l_rd    (l_rd & l_hit[b]),
         .l_addr  (l_addr),
         .l_wdata (l_wdata),
         .l_be    ({l_ube, l_lbe}),
         .r_wr    (r_wr & r_hit[b]),
         .r_rd    (r_rd & r_hit[b]),
         .r_addr  (r_addr),
         .r_wdata (r_wdata),
         .r_be    ({r_ube, r_lbe}),
         .rd_q    (bank_q[b]),
         .to_l_q  (route_l[b]),
         .to_r_q  (route_r[b])
      );
   end

   bsdp_rd_merge #(.BANKS(BANKS), .DATA_W(DATA_W)) u_merge_l (
      .data(bank_q), .route(route_l), .q(l_rdata)
   );

   bsdp_rd_merge #(.BANKS(BANKS), .DATA_W(DATA_W)) u_merge_r (
      .data(bank_q), .route(route_r), .q(r_rdata)
   );

   AST_IDLE_L_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !(l_ce0 && l_ce1) |=> l_rdata == '0); // R3

   AST_IDLE_R_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !(r_ce0 && r_ce1) |=> r_rdata == '0); // R3

   AST_FOREIGN_RD_L: assert property (@(posedge clk) disable iff (!rst_n)
      (l_rd && bank_sel[l_bank]) |=> l_rdata == '0); // R6

   AST_FOREIGN_RD_R: assert property (@(posedge clk) disable iff (!rst_n)
      (r_rd && !bank_sel[r_bank]) |=> r_rdata == '0); // R6

   AST_OE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !l_oe |=> l_rdata == '0); // R8

   AST_UPPER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      !l_ube |=> l_rdata[DATA_W-1:HALF] == '0); // R7

   AST_ROUTE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(route_l) <= 1 && $countones(route_r) <= 1); // R9

endmodule

// File: tb/bsdp_ram_tb_top.sv
module bsdp_ram_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int BANKS = 4;
   localparam int AW    = 8;
   localparam int WORDS = 1 << AW;
   localparam int BA_W  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [BANKS-1:0] bank_sel = '0;
   logic l_ce0 = 0, l_ce1 = 0, l_we = 0, l_oe = 0, l_ube = 0, l_lbe = 0;
   logic r_ce0 = 0, r_ce1 = 0, r_we = 0, r_oe = 0, r_ube = 0, r_lbe = 0;
   logic [BA_W-1:0] l_bank = '0, r_bank = '0;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic [15:0] l_wdata = '0, r_wdata = '0;
   logic [15:0] l_rdata, r_rdata;

   int nvec = 0;
   int nfail = 0;
   string cur_tag = "R11";
   logic [15:0] mdl [BANKS][WORDS];
   logic [15:0] exp_l = '0, exp_r = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bsdp_ram #(.BANKS(BANKS), .BANK_AW(AW), .DATA_W(16)) dut_i (
      .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
      .l_ce0(l_ce0), .l_ce1(l_ce1), .l_we(l_we), .l_oe(l_oe),
      .l_ube(l_ube), .l_lbe(l_lbe), .l_bank(l_bank), .l_addr(l_addr),
      .l_wdata(l_wdata), .l_rdata(l_rdata),
      .r_ce0(r_ce0), .r_ce1(r_ce1), .r_we(r_we), .r_oe(r_oe),
      .r_ube(r_ube), .r_lbe(r_lbe), .r_bank(r_bank), .r_addr(r_addr),
      .r_wdata(r_wdata), .r_rdata(r_rdata)
   );

   function automatic logic [15:0] lanes(logic [15:0] d, logic ub, logic lb);
      return {ub ? d[15:8] : 8'h00, lb ? d[7:0] : 8'h00};
   endfunction

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
   endtask

   task automatic check(string port, logic [15:0] act, logic [15:0] expv);
      nvec++;
      if (act !== expv) begin
         nfail++;
         $display("FAIL %s port %s actual=%h expected=%h t=%0t",
                  cur_tag, port, act, expv, $time);
      end
   endtask

   // one clock: model the edge from the sampled inputs, compare at the falling edge
   task automatic tick();
      logic l_own, r_own;
      @(posedge clk);
      l_own = (bank_sel[l_bank] == 1'b0);
      r_own = (bank_sel[r_bank] == 1'b1);
      exp_l = (l_ce0 && l_ce1 && !l_we && l_oe && l_own)
              ? lanes(mdl[l_bank][l_addr], l_ube, l_lbe) : 16'h0000;
      exp_r = (r_ce0 && r_ce1 && !r_we && r_oe && r_own)
              ? lanes(mdl[r_bank][r_addr], r_ube, r_lbe) : 16'h0000;
      if (l_ce0 && l_ce1 && l_we && l_own) begin
         if (l_ube) mdl[l_bank][l_addr][15:8] = l_wdata[15:8];
         if (l_lbe) mdl[l_bank][l_addr][7:0]  = l_wdata[7:0];
      end
      if (r_ce0 && r_ce1 && r_we && r_own) begin
         if (r_ube) mdl[r_bank][r_addr][15:8] = r_wdata[15:8];
         if (r_lbe) mdl[r_bank][r_addr][7:0]  = r_wdata[7:0];
      end
      @(negedge clk);
      check("L", l_rdata, exp_l);
      check("R", r_rdata, exp_r);
   endtask

   task automatic drv_l(logic c0, logic c1, logic we, logic oe, logic ub, logic lb,
                        int bank, int addr, logic [15:0] wd);
      l_ce0 = c0; l_ce1 = c1; l_we = we; l_oe = oe; l_ube = ub; l_lbe = lb;
      l_bank = BA_W'(bank); l_addr = AW'(addr); l_wdata = wd;
   endtask

   task automatic drv_r(logic c0, logic c1, logic we, logic oe, logic ub, logic lb,
                        int bank, int addr, logic [15:0] wd);
      r_ce0 = c0; r_ce1 = c1; r_we = we; r_oe = oe; r_ube = ub; r_lbe = lb;
      r_bank = BA_W'(bank); r_addr = AW'(addr); r_wdata = wd;
   endtask

   task automatic idle();
      drv_l(0, 0, 0, 0, 0, 0, 0, 0, 16'h0);
      drv_r(0, 0, 0, 0, 0, 0, 0, 0, 16'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      // R11: outputs held at zero during reset
      repeat (3) @(negedge clk);
      cur_tag = "R11";
      check("L", l_rdata, 16'h0000);
      check("R", r_rdata, 16'h0000);
      rst_n = 1'b1;

      // R1 R4: preload every word from the left port while it owns all banks
      cur_tag = "R1";
      bank_sel = '0;
      for (int b = 0; b < BANKS; b++) begin
         for (int a = 0; a < WORDS; a++) begin
            drv_l(1, 1, 1, 0, 1, 1, b, a, 16'(b * 16'h1357 + a * 16'h00A3 + 16'h5000));
            tick();
         end
      end

      // R1 R2: write then read back with one cycle latency
      cur_tag = "R1";
      drv_l(1, 1, 1, 0, 1, 1, 0, 5, 16'hA55A); tick();
      cur_tag = "R2";
      drv_l(1, 1, 0, 1, 1, 1, 0, 5, 16'h0); tick();
      if (l_rdata !== 16'hA55A) begin
         nfail++;
         $display("FAIL R2 actual=%h expected=%h", l_rdata, 16'hA55A);
      end
      nvec++;
      idle(); tick();

      // R3: either chip enable low blocks write and read
      cur_tag = "R3";
      drv_l(1, 0, 1, 0, 1, 1, 0, 5, 16'h1111); tick();
      drv_l(0, 1, 0, 1, 1, 1, 0, 5, 16'h0); tick();
      drv_l(1, 1, 0, 1, 1, 1, 0, 5, 16'h0); tick();

      // R7: byte lanes on write and read
      cur_tag = "R7";
      drv_l(1, 1, 1, 0, 1, 1, 1, 7, 16'h1234); tick();
      drv_l(1, 1, 1, 0, 1, 0, 1, 7, 16'hABCD); tick();
      drv_l(1, 1, 0, 1, 0, 1, 1, 7, 16'h0); tick();
      drv_l(1, 1, 0, 1, 1, 0, 1, 7, 16'h0); tick();
      drv_l(1, 1, 0, 1, 1, 1, 1, 7, 16'h0); tick();

      // R8: output enable low gives zero
      cur_tag = "R8";
      drv_l(1, 1, 0, 0, 1, 1, 1, 7, 16'h0); tick();

      // R5 R6: right port hits a left-owned bank
      cur_tag = "R5";
      idle();
      drv_r(1, 1, 1, 0, 1, 1, 0, 5, 16'hDEAD); tick();
      cur_tag = "R6";
      drv_r(1, 1, 0, 1, 1, 1, 0, 5, 16'h0); tick();
      cur_tag = "R5";
      drv_r(0, 0, 0, 0, 0, 0, 0, 0, 16'h0);
      drv_l(1, 1, 0, 1, 1, 1, 0, 5, 16'h0); tick();

      // R10: hand bank 1 to the right port, contents carry over
      cur_tag = "R10";
      bank_sel = 4'b0010;
      drv_l(0, 0, 0, 0, 0, 0, 0, 0, 16'h0);
      drv_r(1, 1, 0, 1, 1, 1, 1, 7, 16'h0); tick();
      cur_tag = "R6";
      drv_l(1, 1, 0, 1, 1, 1, 1, 7, 16'h0); tick();

      // R9: both ports active on their own banks in the same cycle
      cur_tag = "R9";
      bank_sel = 4'b1100;
      drv_l(1, 1, 1, 0, 1, 1, 0, 9, 16'h0F0F);
      drv_r(1, 1, 1, 0, 1, 1, 3, 9, 16'hF0F0); tick();
      drv_l(1, 1, 0, 1, 1, 1, 0, 9, 16'h0);
      drv_r(1, 1, 0, 1, 1, 1, 3, 9, 16'h0); tick();

      // R4: mixed traffic with changing ownership
      cur_tag = "R4";
      for (int i = 0; i < 600; i++) begin
         if (i % 16 == 0) bank_sel = BANKS'($urandom);
         drv_l(($urandom % 8) != 0, ($urandom % 8) != 0, $urandom % 2, ($urandom % 6) != 0,
               $urandom % 2, $urandom % 2, $urandom % BANKS, $urandom % 16, 16'($urandom));
         drv_r(($urandom % 8) != 0, ($urandom % 8) != 0, $urandom % 2, ($urandom % 6) != 0,
               $urandom % 2, $urandom % 2, $urandom % BANKS, $urandom % 16, 16'($urandom));
         tick();
      end

      idle(); tick();
      summary();
      $finish;
   end

endmodule